// File: doc/BRIEF.md
# Software Breakpoint Handling Controller

This block sits beside a CPU instruction decoder and decides what happens when the decoder reports the breakpoint instruction. The decoder gives a strobe with the decoded opcode. The block then takes one of three actions. It can let the instruction pass as a no-operation. It can stop the CPU and enter debug mode. Or it can hold the program counter so that the CPU keeps fetching the breakpoint again, while interrupt and DMA requests are still granted in the background.

Two configuration bits choose the action: a breakpoint enable and a loop-mode select. These bits are sampled only on a decode strobe. A debugger resume command releases the CPU from a halt or from a loop, and it advances the program counter past the breakpoint. A breakpoint decoded while the CPU runs an interrupt handler always stops the CPU, even in loop mode. This means that background interrupt service needs handlers that contain no breakpoints. The block never enables interrupts itself. It only passes on a request that the CPU's own global interrupt enable already allows.

Top module: `swbp_ctrl`

## Requirements
- R1: During and directly after a synchronous active-low reset, the block is in the running state and `cpu_idle`, `dbg_mode`, `pc_hold` and `pc_advance` are all 0.
- R2: Only a strobe (`dec_valid`=1) whose `dec_opcode` equals 0x00 counts as a breakpoint. Any other opcode, or an opcode with `dec_valid`=0, leaves every output unchanged.
- R3: A breakpoint decoded while `cfg_bp_en`=0 in the running state has no effect and behaves as a no-operation: all outputs stay at their running values.
- R4: A breakpoint decoded with `cfg_bp_en`=1 and `cfg_loop_en`=0 makes `cpu_idle`, `dbg_mode` and `pc_hold` all 1 from the next clock cycle on.
- R5: A breakpoint decoded with `cfg_bp_en`=1, `cfg_loop_en`=1 and `isr_active`=0 enters loop mode from the next cycle on. In loop mode `pc_hold`=1, `cpu_idle`=0 and `dbg_mode`=0.
- R6: While running or looping, `int_grant` equals `int_pending` AND `int_enabled`, and `dma_grant` equals `dma_req`. While halted, both grants are 0.
- R7: `int_grant` is never 1 while `int_enabled` is 0.
- R8: A breakpoint decoded with `cfg_bp_en`=1 and `isr_active`=1 halts the CPU (R4 outputs), even when `cfg_loop_en`=1 and the block is looping.
- R9: In loop mode, a breakpoint decoded again with `isr_active`=0 and both configuration bits at 1 keeps the block in loop mode. Other opcodes decoded during looping, such as handler code, leave it in loop mode.
- R10: The halt is left only by `resume`=1. The next cycle returns to running with `pc_advance`=1 for exactly one cycle. `resume` while already running produces no `pc_advance`.
- R11: While halted, changes to `cfg_bp_en` or `cfg_loop_en` and any decode strobes have no effect. The block stays halted.
- R12: In loop mode, `resume`=1 returns to running with a one-cycle `pc_advance`, and it takes priority over a decode in the same cycle. A breakpoint decoded again with `cfg_bp_en`=0 returns to running without `pc_advance`. One decoded again with `cfg_bp_en`=1 and `cfg_loop_en`=0 halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decoder strobe: an opcode is decoded this cycle |
| dec_opcode | input | OPC_W | Decoded opcode |
| isr_active | input | 1 | CPU is executing inside an interrupt handler |
| cfg_bp_en | input | 1 | Breakpoints enabled |
| cfg_loop_en | input | 1 | Loop on breakpoint instead of halting |
| int_pending | input | 1 | Interrupt controller has a pending request |
| int_enabled | input | 1 | CPU global interrupt enable |
| dma_req | input | 1 | DMA request |
| resume | input | 1 | Debugger resume command |
| cpu_idle | output | 1 | Request to idle the CPU |
| dbg_mode | output | 1 | Debug mode active |
| pc_hold | output | 1 | Hold PC on the breakpoint so it is fetched again |
| pc_advance | output | 1 | One-cycle pulse: step PC past the breakpoint |
| int_grant | output | 1 | Permission to take the pending interrupt |
| dma_grant | output | 1 | Permission to serve the DMA request |

## Verification
Every cycle, assertions check the following: a halt never grants an interrupt or a DMA request, a halt is held until resume, `pc_advance` is a single-cycle pulse, and the three outcomes of a breakpoint decode from the running state. They also check that a breakpoint inside a handler halts the loop. The bench runs a next-state model against the outputs under random stimulus. Only its directed scenarios can show the remaining behaviour: configuration changes made while halted have no effect, a loop survives an interrupt that returns to the held breakpoint, and resume takes priority over a decode in the same cycle.

// File: rtl/swbp_pkg.sv
// Package: shared state type and defaults for the software breakpoint controller.
// Assumes: three control states are enough; encoding is internal only.
package swbp_pkg;
    localparam int OPC_W_DEF = 8;

    typedef enum logic [1:0] {
        BP_RUN  = 2'd0,
        BP_LOOP = 2'd1,
        BP_HALT = 2'd2
    } bp_state_t;
endpackage

// File: rtl/swbp_detect.sv
// Module: swbp_detect
// Recognises the breakpoint opcode on a decode strobe and classifies the
// required action from the configuration bits sampled in that same cycle.
// Assumes: dec_opcode is only meaningful while dec_valid is high.
module swbp_detect #(
    parameter int          OPC_W   = swbp_pkg::OPC_W_DEF,
    parameter logic [OPC_W-1:0] BRK_OPC = '0
) (
    input  logic             dec_valid,
    input  logic [OPC_W-1:0] dec_opcode,
    input  logic             isr_active,
    input  logic             cfg_bp_en,
    input  logic             cfg_loop_en,
    output logic             act_ignore,
    output logic             act_halt,
    output logic             act_loop
);
    logic brk_hit;

    // Match the breakpoint opcode qualified by the strobe.
    always_comb brk_hit = dec_valid && (dec_opcode == BRK_OPC);

    // Classify: disabled -> ignore; in handler or no loop -> halt; else loop.
    always_comb begin
        act_ignore = brk_hit && !cfg_bp_en;
        act_halt   = brk_hit && cfg_bp_en && (!cfg_loop_en || isr_active);
        act_loop   = brk_hit && cfg_bp_en && cfg_loop_en && !isr_active;
    end
endmodule

// File: rtl/swbp_fsm.sv
// Module: swbp_fsm
// Run / loop / halt control. Holds the PC in loop and halt, idles the CPU
// and flags debug mode in halt, pulses pc_advance when resume releases it.
// Assumes: at most one of act_ignore/act_halt/act_loop is high per cycle.
module swbp_fsm
    import swbp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic act_ignore,
    input  logic act_halt,
    input  logic act_loop,
    input  logic resume,
    output logic halted,
    output logic cpu_idle,
    output logic dbg_mode,
    output logic pc_hold,
    output logic pc_advance
);
    bp_state_t state_q, state_d;
    logic      adv_d;

    // Next-state selection; halt ignores everything except resume.
    always_comb begin
        state_d = state_q;
        adv_d   = 1'b0;
        unique case (state_q)
            BP_RUN: begin
                if (act_halt)      state_d = BP_HALT;
                else if (act_loop) state_d = BP_LOOP;
            end
            BP_LOOP: begin
                if (resume) begin
                    state_d = BP_RUN;
                    adv_d   = 1'b1;
                end
                else if (act_halt)   state_d = BP_HALT;
                else if (act_ignore) state_d = BP_RUN;
            end
            BP_HALT: begin
                if (resume) begin
                    state_d = BP_RUN;
                    adv_d   = 1'b1;
                end
            end
            default: state_d = BP_RUN;
        endcase
    end

    // State and advance-pulse registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= BP_RUN;
            pc_advance <= 1'b0;
        end else begin
            state_q    <= state_d;
            pc_advance <= adv_d;
        end
    end

    // Output decode from the state register.
    always_comb begin
        halted   = (state_q == BP_HALT);
        cpu_idle = halted;
        dbg_mode = halted;
        pc_hold  = (state_q != BP_RUN);
    end

    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BP_HALT && !resume) |=> (state_q == BP_HALT));

    p_adv_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_advance |=> !pc_advance);

    p_run_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BP_RUN && act_halt) |=> (cpu_idle && dbg_mode && pc_hold));

    p_run_loop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BP_RUN && act_loop) |=> (pc_hold && !cpu_idle && !dbg_mode));

    p_run_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BP_RUN && act_ignore) |=> (state_q == BP_RUN && !pc_advance));

    p_isr_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BP_LOOP && act_halt && !resume) |=> (state_q == BP_HALT));
endmodule

// File: rtl/swbp_grant.sv
// Module: swbp_grant
// Passes interrupt and DMA requests through unless the CPU is halted.
// Assumes: int_enabled is the CPU's own global enable; it is never forced here.
module swbp_grant (
    input  logic halted,
    input  logic int_pending,
    input  logic int_enabled,
    input  logic dma_req,
    output logic int_grant,
    output logic dma_grant
);
    // Gate requests while halted; interrupts also need the CPU enable.
    always_comb begin
        int_grant = !halted && int_pending && int_enabled;
        dma_grant = !halted && dma_req;
    end
endmodule

// File: rtl/swbp_ctrl.sv
// Module: swbp_ctrl (top)
// Software breakpoint controller: ignore, halt into debug, or loop on the
// breakpoint while interrupts and DMA continue.
// Assumes: decoder, interrupt controller and debug command parser are external.
module swbp_ctrl #(
    parameter int               OPC_W   = swbp_pkg::OPC_W_DEF,
    parameter logic [OPC_W-1:0] BRK_OPC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [OPC_W-1:0] dec_opcode,
    input  logic             isr_active,
    input  logic             cfg_bp_en,
    input  logic             cfg_loop_en,
    input  logic             int_pending,
    input  logic             int_enabled,
    input  logic             dma_req,
    input  logic             resume,
    output logic             cpu_idle,
    output logic             dbg_mode,
    output logic             pc_hold,
    output logic             pc_advance,
    output logic             int_grant,
    output logic             dma_grant
);
    logic act_ignore, act_halt, act_loop, halted;

    swbp_detect #(.OPC_W(OPC_W), .BRK_OPC(BRK_OPC)) u_detect (
        .dec_valid  (dec_valid),
        .dec_opcode (dec_opcode),
        .isr_active (isr_active),
        .cfg_bp_en  (cfg_bp_en),
        .cfg_loop_en(cfg_loop_en),
        .act_ignore (act_ignore),
        .act_halt   (act_halt),
        .act_loop   (act_loop)
    );

    swbp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_ignore(act_ignore),
        .act_halt  (act_halt),
        .act_loop  (act_loop),
        .resume    (resume),
        .halted    (halted),
        .cpu_idle  (cpu_idle),
        .dbg_mode  (dbg_mode),
        .pc_hold   (pc_hold),
        .pc_advance(pc_advance)
    );

    swbp_grant u_grant (
        .halted     (halted),
        .int_pending(int_pending),
        .int_enabled(int_enabled),
        .dma_req    (dma_req),
        .int_grant  (int_grant),
        .dma_grant  (dma_grant)
    );

    p_debug_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode |-> (!int_grant && !dma_grant));

    p_idle_holds_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_idle |-> pc_hold);
endmodule

// File: tb/swbp_ctrl_test.sv
// Bench for swbp_ctrl: directed corner cases plus seeded random stimulus,
// compared every cycle against a next-state model built from the requirements.
module swbp_ctrl_test;
    localparam int OW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dec_valid, isr_active, cfg_bp_en, cfg_loop_en;
    logic [OW-1:0] dec_opcode;
    logic          int_pending, int_enabled, dma_req, resume;
    logic          cpu_idle, dbg_mode, pc_hold, pc_advance, int_grant, dma_grant;

    int checks = 0;
    int errors = 0;
    int m_st   = 0;    // 0 run, 1 loop, 2 halt
    logic m_adv = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    swbp_ctrl uut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_opcode(dec_opcode),
        .isr_active(isr_active), .cfg_bp_en(cfg_bp_en), .cfg_loop_en(cfg_loop_en),
        .int_pending(int_pending), .int_enabled(int_enabled), .dma_req(dma_req),
        .resume(resume), .cpu_idle(cpu_idle), .dbg_mode(dbg_mode), .pc_hold(pc_hold),
        .pc_advance(pc_advance), .int_grant(int_grant), .dma_grant(dma_grant)
    );

    function automatic int f_next(int st);
        logic brk;
        brk = dec_valid && (dec_opcode == 8'h00);
        if (st == 2) return resume ? 0 : 2;
        if (st == 1 && resume) return 0;
        if (brk && cfg_bp_en && (!cfg_loop_en || isr_active)) return 2;
        if (brk && cfg_bp_en) return 1;
        if (brk && st == 1) return 0;
        return st;
    endfunction

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // Compare all outputs against the model; tag names the requirement.
    task automatic check_all(string tag);
        string t;
        t = (tag == "") ? "R4" : tag;
        chk(t, "cpu_idle", cpu_idle, m_st == 2);
        chk(t, "dbg_mode", dbg_mode, m_st == 2);
        t = (tag == "") ? "R5" : tag;
        chk(t, "pc_hold", pc_hold, m_st != 0);
        t = (tag == "") ? "R10" : tag;
        chk(t, "pc_advance", pc_advance, m_adv);
        t = (tag == "") ? "R6" : tag;
        chk(t, "int_grant", int_grant, (m_st != 2) && int_pending && int_enabled);
        chk(t, "dma_grant", dma_grant, (m_st != 2) && dma_req);
        if (int_grant && !int_enabled) chk("R7", "int_grant w/o enable", int_grant, 1'b0);
    endtask

    // One cycle: drive at negedge, check mid-low phase, advance model at the edge.
    task automatic step(string tag, logic v, logic [OW-1:0] op, logic isr,
                        logic en, logic lp, logic ip, logic ie, logic dr, logic rs);
        @(negedge clk);
        dec_valid = v; dec_opcode = op; isr_active = isr; cfg_bp_en = en;
        cfg_loop_en = lp; int_pending = ip; int_enabled = ie; dma_req = dr; resume = rs;
        #4;
        check_all(tag);
        m_adv = rs && (m_st != 0);
        m_st  = f_next(m_st);
    endtask

    task automatic idle_step(string tag);
        step(tag, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        dec_valid = 0; dec_opcode = 0; isr_active = 0; cfg_bp_en = 1; cfg_loop_en = 0;
        int_pending = 0; int_enabled = 0; dma_req = 0; resume = 0;
        // R1: reset with a breakpoint strobe present must stay running
        repeat (2) @(negedge clk);
        dec_valid = 1'b1; resume = 1'b1;
        @(negedge clk); #4;
        chk("R1", "cpu_idle", cpu_idle, 1'b0);
        chk("R1", "dbg_mode", dbg_mode, 1'b0);
        chk("R1", "pc_hold", pc_hold, 1'b0);
        chk("R1", "pc_advance", pc_advance, 1'b0);
        rst_n = 1'b1;
        m_st = 0; m_adv = 1'b0;
        dec_valid = 1'b0; resume = 1'b0;

        // R2: non-breakpoint opcodes and unqualified breakpoints do nothing
        step("R2", 1'b1, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R2", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R2", 1'b1, 8'h80, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        idle_step("R2");
        // R3: disabled breakpoint is a no-op; resume in run gives no advance
        step("R3", 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        idle_step("R3");
        // R4: halt; R11: config flips and strobes ignored; R10: resume pulse
        step("R4", 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        step("R4", 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        step("R11", 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        step("R11", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        idle_step("R10");
        idle_step("R10");
        // R5: loop; R6/R7: grants pass with enable only
        step("R5", 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R6", 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        step("R7", 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        // R9: handler code then return to held breakpoint keeps looping
        step("R9", 1'b1, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        step("R9", 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        // R8: breakpoint inside handler halts the loop
        step("R8", 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        step("R8", 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        idle_step("R10");
        // R12: resume beats a decode in loop; disable exits; loop off halts
        step("R12", 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R12", 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        step("R12", 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R12", 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R12", 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R12", 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R12", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        idle_step("R10");

        // Random phase: per-output default tags
        for (int i = 0; i < 3000; i++) begin
            logic [OW-1:0] op;
            op = ($urandom_range(0, 1) == 0) ? 8'h00 : OW'($urandom_range(0, 255));
            step("", 1'($urandom_range(0, 1)), op, ($urandom_range(0, 3) == 0),
                 ($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule